// File: doc/BRIEF.md
# Byte-Stream Command Register Bank

This block is a bank of eight byte-wide registers that is read and written purely through a stream of bytes. Bytes enter on a valid/ready input stream and responses leave on a matching valid/ready output stream. In a system the input stream is usually fed by a serial receiver and the output stream drains into a serial transmitter, so a host can inspect and modify a handful of control bytes with no other bus.

Each transaction opens with a command byte. Its low nibble is the operation and bits 6:4 pick one of the eight registers. A read returns a single byte holding the register's current contents. A write takes the byte that follows as the new value. Register 0 is fixed to a version constant supplied as a parameter. Writes to it are swallowed, payload included, without effect. A response waiting on a stalled output stream blocks further input until it is taken.

Top module: `bytecmd_regbank`

## Requirements
- R1: After a synchronous active-low reset, registers 1 to 7 read as 0x00, `out_tvalid` is 0 and `in_tready` is 1.
- R2: In a command byte, bits 6:4 give the register address and bits 3:0 give the opcode; bit 7 is ignored and never changes the decoded operation.
- R3: Opcode 0x0 (read) makes `out_tvalid` rise on the clock edge after the command is accepted, with `out_tdata` equal to the addressed register's value at acceptance.
- R4: Opcode 0x1 (write) stores the next accepted input byte into the addressed register, and later reads return that value.
- R5: A response holds `out_tvalid` high and `out_tdata` stable until `out_tready` is seen high; exactly one byte is produced per read.
- R6: Address 0 always reads as the VERSION parameter; a write to it still consumes the payload byte and leaves every register unchanged.
- R7: `in_tready` is 0 while a response is waiting and is 1 at every other time after reset.
- R8: Any opcode other than 0x0 and 0x1 produces no response, consumes no payload, and the next input byte is decoded as a command.
- R9: An input byte is consumed only on an edge where `in_tvalid` and `in_tready` are both 1; idle cycles between a write command and its payload are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_tdata | input | 8 | Input stream byte (command or write payload) |
| in_tvalid | input | 1 | Input byte valid |
| in_tready | output | 1 | Block can accept an input byte |
| out_tdata | output | 8 | Read response byte |
| out_tvalid | output | 1 | Read response valid |
| out_tready | input | 1 | Downstream accepts the response |

## Verification
The bench aims at the protected version slot with a payload that itself looks like a valid write command: a design that fails to consume it would decode it and corrupt register 1, and one that drops protection would return the payload instead of the version. It issues unknown opcodes to catch a design that emits a response or eats the following byte, and sets the reserved bit on both reads and writes to expose decoding that uses it. It stalls the output for several cycles while presenting a new command, which shows a design that loses, changes or repeats the response, or accepts input while a response is pending. It also leaves idle cycles with junk data before a payload, so a design that samples without valid would store garbage.

// File: rtl/regbank_pkg.sv
// Shared constants and types for the byte-stream register bank.
// Assumes a byte-wide stream and a command byte with a 4-bit opcode field.
package regbank_pkg;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam logic [OP_W-1:0] OP_READ  = 4'h0;
    localparam logic [OP_W-1:0] OP_WRITE = 4'h1;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,  // waiting for a command byte
        ST_DATA = 2'd1,  // waiting for a write payload byte
        ST_RESP = 2'd2   // read response held on output
    } ctrl_state_e;
endpackage

// File: rtl/regbank_store.sv
// Register storage: slot 0 is a fixed constant, slots 1..N-1 are writable.
// Assumes one write port and one combinational read port; writes to slot 0
// are dropped here so protection does not depend on the controller.
module regbank_store #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter logic [DATA_W-1:0] VERSION = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREG = 1 << ADDR_W;

    logic [NREG-1:0][DATA_W-1:0] slot;

    // Slot 0 holds the read-only version constant.
    assign slot[0] = VERSION;

    for (genvar i = 1; i < NREG; i++) begin : g_slot
        // Writable slot: clears on reset, loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                slot[i] <= wr_data;
        end
    end

    // Read mux.
    assign rd_data = slot[rd_addr];
endmodule

// File: rtl/regbank_ctrl.sv
// Command sequencer: decodes command bytes, sequences the two-byte write and
// holds one read response until the output stream takes it.
// Assumes in_tdata is stable while in_tvalid is high; input is not accepted
// while a response is pending.
module regbank_ctrl
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic              out_tvalid,
    input  logic              out_tready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int ADDR_LSB = OP_W;

    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] resp_q;
    logic              take;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] cmd_addr;

    // Field extraction; the reserved top bit is never looked at.
    assign opcode   = in_tdata[OP_W-1:0];
    assign cmd_addr = in_tdata[ADDR_LSB +: ADDR_W];

    assign in_tready  = (state_q != ST_RESP);
    assign take       = in_tvalid && in_tready;
    assign out_tvalid = (state_q == ST_RESP);
    assign out_tdata  = resp_q;
    assign rd_addr    = cmd_addr;
    assign wr_addr    = addr_q;
    assign wr_en      = take && (state_q == ST_DATA);

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD: if (take) begin
                if (opcode == OP_READ)       state_d = ST_RESP;
                else if (opcode == OP_WRITE) state_d = ST_DATA;
            end
            ST_DATA: if (take)       state_d = ST_CMD;
            ST_RESP: if (out_tready) state_d = ST_CMD;
            default: state_d = ST_CMD;
        endcase
    end

    // State, write address and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            addr_q  <= '0;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take && state_q == ST_CMD) begin
                addr_q <= cmd_addr;
                if (opcode == OP_READ) resp_q <= rd_data;
            end
        end
    end
endmodule

// File: rtl/bytecmd_regbank.sv
// Top level: eight byte registers reached through a command byte stream.
// Assumes a single clock domain and synchronous active-low reset.
module bytecmd_regbank #(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_tdata,
    input  logic       in_tvalid,
    output logic       in_tready,
    output logic [7:0] out_tdata,
    output logic       out_tvalid,
    input  logic       out_tready
);
    localparam int ADDR_W = 3;
    localparam int DATA_W = regbank_pkg::BYTE_W;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    regbank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tdata  (in_tdata),
        .in_tvalid (in_tvalid),
        .in_tready (in_tready),
        .out_tdata (out_tdata),
        .out_tvalid(out_tvalid),
        .out_tready(out_tready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    regbank_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(in_tdata),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/bytecmd_regbank_chk.sv
// Protocol checker for bytecmd_regbank, attached by bind; observes ports only.
module bytecmd_regbank_chk #(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] in_tdata,
    input logic       in_tvalid,
    input logic       in_tready,
    input logic [7:0] out_tdata,
    input logic       out_tvalid,
    input logic       out_tready
);
    // No input accepted while a response waits.
    assert_ready_low_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_tvalid |-> !in_tready);

    // Stalled response stays put.
    assert_resp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata)));

    // Input reopens once the response is taken.
    assert_ready_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tvalid && out_tready) |=> (in_tready && !out_tvalid));

    // A response only follows an accepted byte carrying the read opcode.
    assert_resp_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_tvalid) |-> ($past(in_tvalid && in_tready) && ($past(in_tdata[3:0]) == 4'h0)));

    // Reads of address 0 return the version.
    assert_version_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_tvalid) && ($past(in_tdata[6:4]) == 3'd0)) |-> (out_tdata == VERSION));
endmodule

bind bytecmd_regbank bytecmd_regbank_chk #(.VERSION(VERSION)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tdata  (in_tdata),
    .in_tvalid (in_tvalid),
    .in_tready (in_tready),
    .out_tdata (out_tdata),
    .out_tvalid(out_tvalid),
    .out_tready(out_tready)
);

// File: tb/bytecmd_regbank_tb_top.sv
// Directed bench for bytecmd_regbank; inputs driven and outputs sampled on
// the falling edge.
module bytecmd_regbank_tb_top;
    localparam logic [7:0] EXP_VER = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_tdata = 8'h00;
    logic       in_tvalid = 1'b0;
    logic       in_tready;
    logic [7:0] out_tdata;
    logic       out_tvalid;
    logic       out_tready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] model [8];

    always #2 clk = ~clk;  // 250 MHz

    bytecmd_regbank #(.VERSION(EXP_VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_tdata(in_tdata), .in_tvalid(in_tvalid),
        .in_tready(in_tready), .out_tdata(out_tdata), .out_tvalid(out_tvalid),
        .out_tready(out_tready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one byte at a negedge and hold it until accepted.
    task automatic send_byte(input logic [7:0] b);
        in_tdata  = b;
        in_tvalid = 1'b1;
        while (!in_tready) @(negedge clk);
        @(negedge clk);
        in_tvalid = 1'b0;
        in_tdata  = 8'hEE;
    endtask

    // Issue a read and take the response after 'stall' cycles.
    task automatic read_reg(input logic [7:0] cmd, input int stall, output logic [7:0] val);
        send_byte(cmd);
        check(out_tvalid === 1'b1, "R3 valid after read", int'(out_tvalid), 1);
        val = out_tdata;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(out_tvalid === 1'b1 && out_tdata === val, "R5 held under stall",
                  int'(out_tdata), int'(val));
        end
        out_tready = 1'b1;
        @(negedge clk);
        out_tready = 1'b0;
        check(out_tvalid === 1'b0, "R5 single byte", int'(out_tvalid), 0);
        check(in_tready === 1'b1, "R7 ready after take", int'(in_tready), 1);
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] data);
        send_byte(cmd);
        send_byte(data);
    endtask

    task automatic test_reset;
        logic [7:0] v;
        check(out_tvalid === 1'b0, "R1 out_tvalid reset", int'(out_tvalid), 0);
        check(in_tready === 1'b1, "R1 in_tready reset", int'(in_tready), 1);
        for (int a = 1; a < 8; a++) begin
            read_reg(8'(a << 4), 0, v);
            check(v === 8'h00, "R1 reg reset value", int'(v), 0);
        end
        read_reg(8'h00, 0, v);
        check(v === EXP_VER, "R6 version read", int'(v), int'(EXP_VER));
    endtask

    task automatic test_write_read;
        logic [7:0] v;
        for (int a = 1; a < 8; a++) begin
            model[a] = 8'(8'h11 * a + 8'h03);
            write_reg(8'(a << 4) | 8'h01, model[a]);
        end
        for (int a = 7; a >= 1; a--) begin
            read_reg(8'(a << 4), 0, v);
            check(v === model[a], "R4 write then read", int'(v), int'(model[a]));
        end
    endtask

    task automatic test_version_protect;
        logic [7:0] v;
        // Payload 0x11 looks like "write reg 1"; it must be eaten as data.
        write_reg(8'h01, 8'h11);
        read_reg(8'h00, 0, v);
        check(v === EXP_VER, "R6 version unchanged", int'(v), int'(EXP_VER));
        read_reg(8'h10, 0, v);
        check(v === model[1], "R6 payload consumed", int'(v), int'(model[1]));
    endtask

    task automatic test_reserved_bit;
        logic [7:0] v;
        model[5] = 8'hC7;
        write_reg(8'hD1, model[5]);       // bit7 set, addr 5, write
        read_reg(8'hD0, 0, v);            // bit7 set, addr 5, read
        check(v === model[5], "R2 reserved bit ignored", int'(v), int'(model[5]));
    endtask

    task automatic test_bad_opcode;
        logic [7:0] v;
        send_byte(8'h32);                 // addr 3, opcode 2
        check(out_tvalid === 1'b0, "R8 no response", int'(out_tvalid), 0);
        send_byte(8'h3F);                 // addr 3, opcode F
        repeat (3) @(negedge clk);
        check(out_tvalid === 1'b0, "R8 still no response", int'(out_tvalid), 0);
        read_reg(8'h30, 0, v);            // next byte is a command
        check(v === model[3], "R8 reg untouched", int'(v), int'(model[3]));
    endtask

    task automatic test_backpressure;
        logic [7:0] v;
        send_byte(8'h60);                 // read reg 6
        v = out_tdata;
        in_tdata  = 8'h61;                // pending write cmd must wait
        in_tvalid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            check(in_tready === 1'b0, "R7 blocked while busy", int'(in_tready), 0);
            check(out_tvalid === 1'b1 && out_tdata === model[6], "R5 stall stable",
                  int'(out_tdata), int'(model[6]));
            @(negedge clk);
        end
        in_tvalid = 1'b0;
        out_tready = 1'b1;
        @(negedge clk);
        out_tready = 1'b0;
        check(out_tvalid === 1'b0 && in_tready === 1'b1, "R7 released",
              int'(in_tready), 1);
        read_reg(8'h60, 4, v);
        check(v === model[6], "R9 stalled cmd not taken", int'(v), int'(model[6]));
    endtask

    task automatic test_idle_gap;
        logic [7:0] v;
        send_byte(8'h21);                 // write reg 2
        in_tdata = 8'hBB;                 // junk with valid low
        repeat (4) @(negedge clk);
        model[2] = 8'h4D;
        send_byte(model[2]);
        read_reg(8'h20, 2, v);
        check(v === model[2], "R9 idle gap before payload", int'(v), int'(model[2]));
    endtask

    initial begin
        for (int a = 0; a < 8; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write_read();
        test_version_protect();
        test_reserved_bit();
        test_bad_opcode();
        test_backpressure();
        test_idle_gap();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule